// File: doc/BRIEF.md
# In-Lane Byte Shuffle Unit

This unit rearranges the bytes of a 256-bit data vector under the control of a 256-bit control vector that is supplied with each operation. The vector is split into two 128-bit lanes that work independently. Each output byte is taken from one of the 16 bytes in its own lane. The low four bits of the matching control byte choose that source byte. Bytes never move from one lane into the other.

Because the index is four bits wide, the unit can also serve as 32 parallel table lookups. The data vector holds one 16-entry table of byte values per lane, and each control byte is a 4-bit index into the table of its lane. If the top bit of a control byte is set, the output byte is forced to zero.

The result is registered, so it appears one cycle after the operation is presented. A new operation can be accepted on every clock cycle. An output valid flag follows the input valid flag by one cycle. While no operation is presented, the output register keeps its last value.

Top module: `byte_lane_shuffle`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and result_o is all zeros.
- R2: valid_o equals the valid_i sampled at the previous rising clock edge.
- R3: If bit 7 of control byte k is 1, output byte k of the accepted operation is 0x00.
- R4: If bit 7 of control byte k is 0, output byte k equals data byte 16*L + ctrl[3:0], where L = k/16 is the lane of byte k. Byte k occupies bits 8k+7 down to 8k.
- R5: Control bits 6 to 4 have no effect on the result.
- R6: Output bytes in lane 0 (bytes 0 to 15) are drawn only from data bytes 0 to 15, and output bytes in lane 1 (bytes 16 to 31) only from data bytes 16 to 31.
- R7: Operations presented on consecutive cycles each produce their own result, one cycle after they are presented.
- R8: When valid_i is 0, result_o keeps its previous value at the next edge.
- R9: With the data vector holding a 16-entry byte table per lane, each output byte is the table entry of its lane at the 4-bit index in the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present |
| data_i | input | 256 | Source bytes, or the table contents |
| ctrl_i | input | 256 | One control byte per output byte |
| valid_o | output | 1 | Result valid |
| result_o | output | 256 | Shuffled bytes |

## Verification
The unit has no state beyond the output register and the valid flag. A wrong selection, a missed zero, or a byte that leaks across the lane boundary therefore shows up as a bad result_o byte on the cycle right after the operation. A register that loads while idle, or a valid flag that is held or delayed by the wrong amount, is seen at the ports on the next edge. The scoreboard compares every cycle, including idle cycles, so each of these errors is caught within one clock.

// File: rtl/lane_shuf_pkg.sv
package lane_shuf_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ZERO_BIT  = 7;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/shuf_byte_sel.sv
module shuf_byte_sel
  import lane_shuf_pkg::*;
#(
  parameter int unsigned LANE_BYTES = 16,
  localparam int unsigned IDX_W     = $clog2(LANE_BYTES),
  localparam int unsigned LANE_W    = LANE_BYTES * BYTE_W
) (
  input  logic [LANE_W-1:0] lane_data_i,
  input  byte_t             ctrl_i,
  output byte_t             byte_o
);
  logic [IDX_W-1:0] idx;
  assign idx = ctrl_i[IDX_W-1:0];

  always_comb begin
    if (ctrl_i[ZERO_BIT]) byte_o = '0;
    else                  byte_o = lane_data_i[idx*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/shuf_lane.sv
module shuf_lane
  import lane_shuf_pkg::*;
#(
  parameter int unsigned LANE_BYTES = 16,
  localparam int unsigned LANE_W    = LANE_BYTES * BYTE_W
) (
  input  logic [LANE_W-1:0] data_i,
  input  logic [LANE_W-1:0] ctrl_i,
  output logic [LANE_W-1:0] result_o
);
  for (genvar j = 0; j < LANE_BYTES; j++) begin : g_byte
    shuf_byte_sel #(.LANE_BYTES(LANE_BYTES)) u_sel (
      .lane_data_i (data_i),
      .ctrl_i      (ctrl_i[j*BYTE_W +: BYTE_W]),
      .byte_o      (result_o[j*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/byte_lane_shuffle.sv
module byte_lane_shuffle
  import lane_shuf_pkg::*;
#(
  parameter int unsigned LANES      = 2,
  parameter int unsigned LANE_BYTES = 16,
  localparam int unsigned LANE_W    = LANE_BYTES * BYTE_W,
  localparam int unsigned VEC_W     = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] data_i,
  input  logic [VEC_W-1:0] ctrl_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] result_o
);
  logic [VEC_W-1:0] res_d;

  // lanes never see each other's data
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    shuf_lane #(.LANE_BYTES(LANE_BYTES)) u_lane (
      .data_i   (data_i[l*LANE_W +: LANE_W]),
      .ctrl_i   (ctrl_i[l*LANE_W +: LANE_W]),
      .result_o (res_d[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  // R1
  always_comb begin
    if (!rst_ni) reset_clear_chk: assert (result_o == '0 && !valid_o);
  end

  for (genvar k = 0; k < LANES*LANE_BYTES; k++) begin : g_zchk
    // R3
    zero_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && ctrl_i[k*BYTE_W + ZERO_BIT]) |=> (result_o[k*BYTE_W +: BYTE_W] == '0));
  end
endmodule

// File: tb/byte_lane_shuffle_tb_top.sv
module byte_lane_shuffle_tb_top;
  localparam int W = 256;

  logic clk = 0, rst_ni = 0, valid_i = 0;
  logic [W-1:0] data_i = '0, ctrl_i = '0;
  logic valid_o;
  logic [W-1:0] result_o;

  always #2 clk = ~clk;

  byte_lane_shuffle dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .ctrl_i(ctrl_i), .valid_o(valid_o), .result_o(result_o));

  typedef struct { logic v; logic [W-1:0] r; int req; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  logic [W-1:0] last_res = '0;
  bit done = 0;

  function automatic logic [W-1:0] model(logic [W-1:0] d, logic [W-1:0] c);
    logic [W-1:0] r;
    for (int k = 0; k < 32; k++) begin
      logic [7:0] cb;
      int src;
      cb  = c[k*8 +: 8];
      src = (k / 16) * 16 + int'(cb[3:0]);
      r[k*8 +: 8] = cb[7] ? 8'h00 : d[src*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic drive(logic v, logic [W-1:0] d, logic [W-1:0] c, int req);
    exp_t e;
    @(negedge clk);
    valid_i = v; data_i = d; ctrl_i = c;
    if (v) last_res = model(d, c);
    e.v = v; e.r = last_res; e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (valid_o !== e.v || result_o !== e.r) begin
          n_bad++;
          $display("FAIL R%0d: valid %0b res %h / expected valid %0b res %h",
                   e.req, valid_o, result_o, e.v, e.r);
        end
      end
    end
  end

  initial begin : stim
    logic [W-1:0] c, d, c2;
    #7;
    // R1 reset state
    n_chk++;
    if (valid_o !== 1'b0 || result_o !== '0) begin
      n_bad++;
      $display("FAIL R1: valid %0b res %h / expected 0 0", valid_o, result_o);
    end
    @(negedge clk); rst_ni = 1;

    // R4 identity
    for (int k = 0; k < 32; k++) c[k*8 +: 8] = 8'(k % 16);
    drive(1, rnd(), c, 4);
    // R4 reversal
    for (int k = 0; k < 32; k++) c[k*8 +: 8] = 8'(15 - k % 16);
    drive(1, rnd(), c, 4);
    // R6 broadcast index 5: lane 0 gets byte 5, lane 1 gets byte 21
    for (int k = 0; k < 32; k++) c[k*8 +: 8] = 8'h05;
    drive(1, rnd(), c, 6);
    // R6 index 15 on every byte: must not cross into the other lane
    for (int k = 0; k < 32; k++) c[k*8 +: 8] = 8'h0F;
    drive(1, rnd(), c, 6);
    // R3 zeroing, all and mixed
    for (int k = 0; k < 32; k++) c[k*8 +: 8] = 8'h80 | 8'(k);
    drive(1, rnd(), c, 3);
    c = rnd();
    drive(1, rnd(), c, 3);
    // R5 bits 6:4 ignored: same data, clean and noisy control give same result
    d = rnd();
    for (int k = 0; k < 32; k++) c[k*8 +: 8] = 8'($urandom % 16);
    c2 = c;
    for (int k = 0; k < 32; k++) c2[k*8 + 4 +: 3] = 3'($urandom);
    drive(1, d, c, 5);
    drive(1, d, c2, 5);
    // R9 table lookup: lane L entry i = i*i + 3*L
    for (int k = 0; k < 32; k++) d[k*8 +: 8] = 8'((k % 16) * (k % 16) + 3 * (k / 16));
    for (int k = 0; k < 32; k++) c[k*8 +: 8] = 8'($urandom % 16);
    drive(1, d, c, 9);
    // R8 idle with new inputs: hold
    drive(0, rnd(), rnd(), 8);
    drive(0, rnd(), rnd(), 8);
    // R2 toggling valid
    for (int i = 0; i < 20; i++) drive(1'(i % 3 != 0), rnd(), rnd(), 2);
    // R7 back-to-back random stream
    for (int i = 0; i < 300; i++) drive(1, rnd(), rnd(), 7);
    drive(0, '0, '0, 8);
    drive(0, '0, '0, 8);
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R7: watchdog expired / expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule